// File: doc/BRIEF.md
# Privileged Interrupt Priority Selector

This block decides, from the current interrupt state of a hart, whether an interrupt should be taken now and which one. It forms the candidate set from the pending and enable vectors. It then splits the candidates by delegation. Candidates that stay at machine level are gated by the machine-level global enable. Delegated candidates are gated by the supervisor-level global enable. Both enables depend on the current privilege. Among the survivors, the lowest-numbered interrupt wins.

When virtualization is switched on, selection runs in two tiers. The host (hypervisor-level) candidates are tried first, under their own supervisor-enable bit. A hit raises a flag that tells the trap logic to deliver the interrupt to the hypervisor. If there is no host hit, the three guest interrupt lines (bits 2, 6 and 10) are moved down one position and pass through the ordinary delegation and enable gating.

The result is held in a register for one cycle so that the block can sit directly in front of a pipeline stage. A parameter can select a purely combinational output instead.

Top module: `irq_prio_sel`

## Requirements
- R1: An interrupt is a candidate only when both its `pend_i` bit and its `enab_i` bit are 1. If the candidate set is empty, `take_o` is 0.
- R2: Candidates whose `deleg_i` bit is 0 are allowed when privilege is below machine (code 3), or when privilege is machine and `mie_i` is 1.
- R3: Candidates whose `deleg_i` bit is 1 are allowed when privilege is user (code 0), or when privilege is supervisor (code 1) and `sie_i` is 1. They are never allowed at machine privilege.
- R4: Each candidate is gated by exactly one enable, and its `deleg_i` bit decides which one. Undelegated and delegated candidates can be enabled at the same time.
- R5: `idx_o` is the position of the lowest-numbered allowed candidate. When nothing is allowed, `take_o` is 0 and `idx_o` is 0.
- R6: When `virt_i` is 1, candidates other than bits 2, 6 and 10 form a first tier. This tier is allowed when privilege is user, or when privilege is supervisor and `hyp_sie_i` is 1; delegation is ignored here. If any first-tier candidate is allowed, the lowest one is reported with `to_hyp_o` = 1.
- R7: When `virt_i` is 1 and no first-tier candidate is allowed, only candidate bits 2, 6 and 10 are considered, moved to positions 1, 5 and 9. They then follow R2 to R5 using the `deleg_i` bit of the new position, and `to_hyp_o` is 0.
- R8: When `virt_i` is 0, `to_hyp_o` is 0, `hyp_sie_i` has no effect, and bits 2, 6 and 10 are treated like any other bit.
- R9: With the registered output (default), results appear on the clock edge after the inputs. A synchronous reset clears `take_o`, `idx_o` and `to_hyp_o` to 0.
- R10: Privilege code 2 is treated as lying above supervisor and below machine: undelegated candidates are allowed and delegated ones are not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| pend_i | input | 16 | Pending interrupt vector |
| enab_i | input | 16 | Per-interrupt enable vector |
| deleg_i | input | 16 | Delegation mask, 1 = handled at supervisor level |
| priv_i | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| mie_i | input | 1 | Machine global interrupt enable |
| sie_i | input | 1 | Supervisor global interrupt enable |
| hyp_sie_i | input | 1 | Host supervisor interrupt enable used in virtualized mode |
| virt_i | input | 1 | Virtualization mode active |
| take_o | output | 1 | An interrupt should be taken |
| idx_o | output | 5 | Index of the chosen interrupt |
| to_hyp_o | output | 1 | Chosen interrupt must be delivered to the hypervisor |

## Verification
Dense pending vectors with a single enable bit separate the candidate AND from the priority encoder. Vectors with one delegated and one undelegated bit, swept through the privilege codes and enable bits, show which enable gates which half. In virtualized mode, vectors that mix guest and host bits tell the host tier, the one-position remap and the force flag apart. The same guest bits with virtualization off confirm that none of that machinery leaks. A seeded random sweep over all privilege codes is then compared against an independent reference model in the bench.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;

    typedef enum logic [1:0] {
        PRIV_USER = 2'd0,
        PRIV_SUPV = 2'd1,
        PRIV_RSVD = 2'd2,
        PRIV_MACH = 2'd3
    } priv_e;

    localparam int unsigned IRQ_W_DEF     = 16;
    localparam int unsigned GUEST_SW_POS  = 2;
    localparam int unsigned GUEST_TMR_POS = 6;
    localparam int unsigned GUEST_EXT_POS = 10;

    // Global enable for one level: any lower privilege is always open,
    // the same privilege is open only with its enable bit.
    function automatic logic level_open(priv_e cur, priv_e lvl, logic en_bit);
        return (cur < lvl) || ((cur == lvl) && en_bit);
    endfunction

    function automatic logic [31:0] guest_bits();
        logic [31:0] m;
        m = '0;
        m[GUEST_SW_POS]  = 1'b1;
        m[GUEST_TMR_POS] = 1'b1;
        m[GUEST_EXT_POS] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/irq_sel_gate.sv
module irq_sel_gate #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] cand_i,
    input  logic [W-1:0] deleg_i,
    input  logic         m_open_i,
    input  logic         s_open_i,
    output logic [W-1:0] allowed_o
);
    always_comb begin
        allowed_o = (cand_i & ~deleg_i & {W{m_open_i}})
                  | (cand_i &  deleg_i & {W{s_open_i}});
    end
endmodule

// File: rtl/irq_sel_pick.sv
module irq_sel_pick #(
    parameter int unsigned W  = 16,
    parameter int unsigned IW = 5
) (
    input  logic [W-1:0]  vec_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);
    // Lowest set bit wins: scan from the top so the last hit is the lowest.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                found_o = 1'b1;
                idx_o   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/irq_sel_stage.sv
module irq_sel_stage #(
    parameter int unsigned IW      = 5,
    parameter bit          REG_OUT = 1'b1
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          take_d,
    input  logic [IW-1:0] idx_d,
    input  logic          hyp_d,
    output logic          take_q,
    output logic [IW-1:0] idx_q,
    output logic          hyp_q
);
    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk_i) begin
                if (rst_i) begin
                    take_q <= 1'b0;
                    idx_q  <= '0;
                    hyp_q  <= 1'b0;
                end else begin
                    take_q <= take_d;
                    idx_q  <= idx_d;
                    hyp_q  <= hyp_d;
                end
            end
        end else begin : g_comb
            logic unused_clk;
            assign unused_clk = clk_i ^ rst_i;
            assign take_q = take_d;
            assign idx_q  = idx_d;
            assign hyp_q  = hyp_d;
        end
    endgenerate
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
    import irq_sel_pkg::*;
#(
    parameter int unsigned IRQ_W   = IRQ_W_DEF,
    parameter bit          REG_OUT = 1'b1,
    localparam int unsigned IDX_W  = $clog2(IRQ_W) + 1
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [IRQ_W-1:0] pend_i,
    input  logic [IRQ_W-1:0] enab_i,
    input  logic [IRQ_W-1:0] deleg_i,
    input  logic [1:0]       priv_i,
    input  logic             mie_i,
    input  logic             sie_i,
    input  logic             hyp_sie_i,
    input  logic             virt_i,
    output logic             take_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             to_hyp_o
);
    localparam logic [IRQ_W-1:0] GMASK = IRQ_W'(guest_bits());

    priv_e            cur_priv;
    logic             m_open, s_open, h_open;
    logic [IRQ_W-1:0] cand, host_vec, tier2_src, tier2_ok;
    logic             host_hit, norm_hit;
    logic [IDX_W-1:0] host_idx, norm_idx;
    logic             take_d, hyp_d;
    logic [IDX_W-1:0] idx_d;

    always_comb begin
        cur_priv = priv_e'(priv_i);
        m_open   = level_open(cur_priv, PRIV_MACH, mie_i);
        s_open   = level_open(cur_priv, PRIV_SUPV, sie_i);
        h_open   = level_open(cur_priv, PRIV_SUPV, hyp_sie_i);
        cand     = pend_i & enab_i;
        host_vec = virt_i ? (cand & ~GMASK & {IRQ_W{h_open}}) : '0;
        tier2_src = virt_i ? ((cand & GMASK) >> 1) : cand;
    end

    irq_sel_pick #(.W(IRQ_W), .IW(IDX_W)) u_pick_host (
        .vec_i   (host_vec),
        .found_o (host_hit),
        .idx_o   (host_idx)
    );

    irq_sel_gate #(.W(IRQ_W)) u_gate (
        .cand_i    (tier2_src),
        .deleg_i   (deleg_i),
        .m_open_i  (m_open),
        .s_open_i  (s_open),
        .allowed_o (tier2_ok)
    );

    irq_sel_pick #(.W(IRQ_W), .IW(IDX_W)) u_pick_norm (
        .vec_i   (tier2_ok),
        .found_o (norm_hit),
        .idx_o   (norm_idx)
    );

    always_comb begin
        if (host_hit) begin
            take_d = 1'b1;
            idx_d  = host_idx;
            hyp_d  = 1'b1;
        end else begin
            take_d = norm_hit;
            idx_d  = norm_idx;
            hyp_d  = 1'b0;
        end
    end

    irq_sel_stage #(.IW(IDX_W), .REG_OUT(REG_OUT)) u_stage (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .take_d (take_d),
        .idx_d  (idx_d),
        .hyp_d  (hyp_d),
        .take_q (take_o),
        .idx_q  (idx_o),
        .hyp_q  (to_hyp_o)
    );

    generate
        if (REG_OUT) begin : g_chk
            logic [IRQ_W-1:0] cand_q;
            logic             virt_q;
            always_ff @(posedge clk_i) begin
                if (rst_i) begin
                    cand_q <= '0;
                    virt_q <= 1'b0;
                end else begin
                    cand_q <= pend_i & enab_i;
                    virt_q <= virt_i;
                end
            end

            assert_empty_no_take_R1: assert property (@(posedge clk_i) disable iff (rst_i)
                ((pend_i & enab_i) == '0) |=> !take_o);

            assert_mach_closed_R2: assert property (@(posedge clk_i) disable iff (rst_i)
                (priv_i == 2'd3 && !mie_i && !virt_i) |=> !take_o);

            assert_user_open_R3: assert property (@(posedge clk_i) disable iff (rst_i)
                (priv_i == 2'd0 && !virt_i && (pend_i & enab_i) != '0) |=> take_o);

            assert_deleg_blocked_in_mach_R4: assert property (@(posedge clk_i) disable iff (rst_i)
                (priv_i == 2'd3 && !virt_i && (pend_i & enab_i & ~deleg_i) == '0) |=> !take_o);

            assert_idx_is_candidate_R5: assert property (@(posedge clk_i) disable iff (rst_i)
                (take_o && !virt_q) |-> cand_q[idx_o]);

            assert_hyp_needs_virt_R6: assert property (@(posedge clk_i) disable iff (rst_i)
                to_hyp_o |-> (take_o && virt_q));

            assert_reset_clears_R9: assert property (@(posedge clk_i)
                rst_i |=> (!take_o && !to_hyp_o && idx_o == '0));
        end
    endgenerate
endmodule

// File: tb/irq_prio_sel_tb_top.sv
module irq_prio_sel_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] pend, enab, deleg;
    logic [1:0]  priv;
    logic        mie, sie, hsie, virt;
    logic        take;
    logic [4:0]  idx;
    logic        tohyp;

    int n_run  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    irq_prio_sel dut_i (
        .clk_i(clk), .rst_i(rst), .pend_i(pend), .enab_i(enab), .deleg_i(deleg),
        .priv_i(priv), .mie_i(mie), .sie_i(sie), .hyp_sie_i(hsie), .virt_i(virt),
        .take_o(take), .idx_o(idx), .to_hyp_o(tohyp)
    );

    // Independent reference: returns {take, force, idx}
    function automatic logic [6:0] ref_sel(logic [15:0] p, logic [15:0] e, logic [15:0] d,
                                           logic [1:0] pr, logic m, logic s, logic h, logic v);
        logic [15:0] c, hc, g;
        logic mo, so, ho;
        c  = p & e;
        mo = (pr != 2'd3) || m;
        so = (pr == 2'd0) || (pr == 2'd1 && s);
        ho = (pr == 2'd0) || (pr == 2'd1 && h);
        if (v) begin
            hc = c & ~16'h0444;
            if (ho) begin
                for (int k = 0; k < 16; k++)
                    if (hc[k]) return {1'b1, 1'b1, 5'(k)};
            end
            c = {1'b0, c[15:1]} & 16'h0222;
        end
        for (int k = 0; k < 16; k++) begin
            g[k] = c[k] && (d[k] ? so : mo);
        end
        for (int k = 0; k < 16; k++)
            if (g[k]) return {1'b1, 1'b0, 5'(k)};
        return 7'd0;
    endfunction

    task automatic compare(string req, logic et, logic [4:0] ei, logic ef);
        n_run++;
        if (take !== et || idx !== ei || tohyp !== ef) begin
            n_fail++;
            $display("FAIL %s: got take=%0b idx=%0d hyp=%0b exp take=%0b idx=%0d hyp=%0b",
                     req, take, idx, tohyp, et, ei, ef);
        end
    endtask

    task automatic drive(logic [15:0] p, logic [15:0] e, logic [15:0] d, logic [1:0] pr,
                         logic m, logic s, logic h, logic v);
        @(negedge clk);
        pend = p; enab = e; deleg = d; priv = pr; mie = m; sie = s; hsie = h; virt = v;
        @(negedge clk);
    endtask

    task automatic vec(string req, logic [15:0] p, logic [15:0] e, logic [15:0] d, logic [1:0] pr,
                       logic m, logic s, logic h, logic v, logic et, logic [4:0] ei, logic ef);
        logic [6:0] r;
        drive(p, e, d, pr, m, s, h, v);
        compare(req, et, ei, ef);
        r = ref_sel(p, e, d, pr, m, s, h, v);
        compare({req, "-model"}, r[6], r[4:0], r[5]);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        pend = '1; enab = '1; deleg = '0; priv = 2'd0; mie = 1; sie = 1; hsie = 1; virt = 0;
        repeat (3) @(negedge clk);
        compare("R9 reset", 1'b0, 5'd0, 1'b0);
        rst = 1'b0;
    endtask

    task automatic t_candidates();
        vec("R1 no enable", 16'hFFFF, 16'h0000, 16'h0, 2'd0, 1, 1, 0, 0, 0, 0, 0);
        vec("R1 no pending", 16'h0000, 16'hFFFF, 16'h0, 2'd0, 1, 1, 0, 0, 0, 0, 0);
        vec("R5 single enable", 16'hFFFF, 16'h0200, 16'h0, 2'd0, 1, 1, 0, 0, 1, 9, 0);
        vec("R5 lowest wins", 16'h8890, 16'hFFF0, 16'h0, 2'd3, 1, 0, 0, 0, 1, 4, 0);
        vec("R5 top bit", 16'h8000, 16'h8000, 16'h0, 2'd1, 0, 0, 0, 0, 1, 15, 0);
    endtask

    task automatic t_machine();
        vec("R2 mach closed", 16'h0080, 16'hFFFF, 16'h0, 2'd3, 0, 1, 0, 0, 0, 0, 0);
        vec("R2 mach open", 16'h0080, 16'hFFFF, 16'h0, 2'd3, 1, 0, 0, 0, 1, 7, 0);
        vec("R2 below mach", 16'h0080, 16'hFFFF, 16'h0, 2'd1, 0, 0, 0, 0, 1, 7, 0);
    endtask

    task automatic t_supervisor();
        vec("R3 supv closed", 16'h0020, 16'hFFFF, 16'hFFFF, 2'd1, 1, 0, 0, 0, 0, 0, 0);
        vec("R3 supv open", 16'h0020, 16'hFFFF, 16'hFFFF, 2'd1, 0, 1, 0, 0, 1, 5, 0);
        vec("R3 user open", 16'h0020, 16'hFFFF, 16'hFFFF, 2'd0, 0, 0, 0, 0, 1, 5, 0);
        vec("R3 mach blocks deleg", 16'h0020, 16'hFFFF, 16'hFFFF, 2'd3, 1, 1, 0, 0, 0, 0, 0);
    endtask

    task automatic t_deleg();
        // bit 1 delegated, bit 8 not
        vec("R4 supv sie0 takes undeleg", 16'h0102, 16'hFFFF, 16'h0002, 2'd1, 0, 0, 0, 0, 1, 8, 0);
        vec("R4 supv sie1 takes deleg", 16'h0102, 16'hFFFF, 16'h0002, 2'd1, 0, 1, 0, 0, 1, 1, 0);
        vec("R4 mach takes undeleg", 16'h0102, 16'hFFFF, 16'h0002, 2'd3, 1, 1, 0, 0, 1, 8, 0);
    endtask

    task automatic t_virt_host();
        vec("R6 host wins", 16'h0884, 16'hFFFF, 16'h0, 2'd1, 1, 1, 1, 1, 1, 7, 1);
        vec("R6 host lowest", 16'h0109, 16'hFFFF, 16'hFFFF, 2'd0, 0, 0, 0, 1, 1, 0, 1);
        vec("R6 host gated by hyp_sie", 16'h0080, 16'hFFFF, 16'h0, 2'd1, 1, 1, 0, 1, 0, 0, 0);
        vec("R6 host closed in mach", 16'h0080, 16'hFFFF, 16'h0, 2'd3, 1, 1, 1, 1, 0, 0, 0);
    endtask

    task automatic t_virt_guest();
        vec("R7 guest ext remap", 16'h0400, 16'hFFFF, 16'h0, 2'd1, 1, 0, 0, 1, 1, 9, 0);
        vec("R7 guest lowest remap", 16'h0444, 16'hFFFF, 16'h0, 2'd1, 1, 0, 0, 1, 1, 1, 0);
        vec("R7 remap uses new deleg bit", 16'h0040, 16'hFFFF, 16'h0020, 2'd1, 1, 0, 1, 1, 0, 0, 0);
        vec("R7 remap deleg open", 16'h0040, 16'hFFFF, 16'h0020, 2'd1, 0, 1, 0, 1, 1, 5, 0);
        vec("R7 host blocked falls back", 16'h0084, 16'hFFFF, 16'h0, 2'd1, 1, 0, 0, 1, 1, 1, 0);
    endtask

    task automatic t_virt_off();
        vec("R8 guest bit plain", 16'h0004, 16'hFFFF, 16'h0, 2'd1, 1, 0, 1, 0, 1, 2, 0);
        vec("R8 hyp_sie ignored", 16'h0080, 16'hFFFF, 16'hFFFF, 2'd1, 1, 0, 1, 0, 0, 0, 0);
    endtask

    task automatic t_rsvd_priv();
        vec("R10 code2 undeleg", 16'h0010, 16'hFFFF, 16'h0, 2'd2, 0, 1, 0, 0, 1, 4, 0);
        vec("R10 code2 deleg", 16'h0010, 16'hFFFF, 16'hFFFF, 2'd2, 1, 1, 0, 0, 0, 0, 0);
    endtask

    task automatic t_latency();
        logic [6:0] r;
        drive(16'h0008, 16'hFFFF, 16'h0, 2'd0, 1, 1, 0, 0);
        @(negedge clk);
        pend = 16'h1000;
        #1;
        compare("R9 holds before edge", 1'b1, 5'd3, 1'b0);
        @(negedge clk);
        r = ref_sel(pend, enab, deleg, priv, mie, sie, hsie, virt);
        compare("R9 updates after edge", r[6], r[4:0], r[5]);
    endtask

    task automatic t_random();
        int unsigned seed;
        logic [6:0] r;
        seed = 32'h5eed;
        void'($urandom(seed));
        for (int n = 0; n < 3000; n++) begin
            logic [15:0] p, e, d;
            logic [3:0]  b;
            logic [1:0]  pr;
            p = 16'($urandom) & 16'($urandom);
            e = 16'($urandom);
            d = 16'($urandom);
            pr = 2'(n % 4);
            b = 4'($urandom);
            drive(p, e, d, pr, b[0], b[1], b[2], b[3]);
            r = ref_sel(p, e, d, pr, b[0], b[1], b[2], b[3]);
            compare("R5 R6 R7 random sweep", r[6], r[4:0], r[5]);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_candidates();
        t_machine();
        t_supervisor();
        t_deleg();
        t_virt_host();
        t_virt_guest();
        t_virt_off();
        t_rsvd_priv();
        t_latency();
        t_random();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule